// File: doc/BRIEF.md
# Epoch-Based Backplane Transfer Allocator

This block decides, once per epoch, which cards on a switched backplane may send to which other cards. Every card can ask to reach any destination card. At each epoch boundary the block samples the full request matrix, a forwarding-engine flag for each source and an inhibit line from each destination. During the following epoch it works out a set of source-to-destination pairings in which no source and no destination appears twice. At the next boundary it publishes that set, and the set then stays unchanged for a whole epoch.

The scan is greedy and runs over two passes. Sources flagged as forwarding engines are visited first, and all other sources follow in a second pass. Several sources are evaluated in each allocation clock, so that both passes over all sources finish within one epoch. A low source number gives no standing advantage, because the order in which sources and destinations are visited is rotated every epoch by offsets taken from a 16-bit LFSR. The LFSR seed can be loaded so that a test run can be repeated exactly.

The card-facing pins carry no handshake. Each epoch the block samples its inputs unconditionally at the boundary and drives its outputs as levels for the whole epoch. Back-pressure is applied only through the per-destination inhibit lines, so there are no valid/ready pairs to stall. An epoch is `EPOCH_CYC` allocation clocks long (default 8).

Top module: `epoch_xfer_alloc`

## Requirements
- R1: `epoch_tick` is high in exactly one cycle out of every `EPOCH_CYC` cycles. After reset is released it first rises in the cycle that ends with the `EPOCH_CYC`-th rising edge.
- R2: `req_mat`, `fe_pri` and `dst_inhibit` are sampled at the rising edge at which `epoch_tick` is high. The grant set computed from them appears after the next such edge and stays unchanged for `EPOCH_CYC` cycles.
- R3: Each source is granted at most one destination, and each destination is given to at most one source. `dst_sel_vld[d]`/`dst_sel_src[d*IW +: IW]` mirror exactly the grants `src_gnt_vld[s]`/`src_gnt_dst[s*IW +: IW]`. Fields that are not granted read zero.
- R4: A pair (s, d) is granted only when request bit `req_mat[s*N+d]` was set in the sampled matrix.
- R5: A destination whose `dst_inhibit` bit was set in the sample is never granted in the matching epoch. With every bit set, there are no grants at all.
- R6: The grant set is maximal. No requested, non-inhibited pair is left where both the source and the destination are still ungranted.
- R7: A forwarding-engine source (`fe_pri` bit set) is never denied a requested, non-inhibited destination in favour of a source without the flag.
- R8: The scan order is fixed by two offsets taken from the LFSR value at the sampling edge: so = lfsr[3:0] mod N and sd = lfsr[7:4] mod N. Pass 1 visits sources (j+so) mod N for j=0..N-1 that have the flag set, and pass 2 visits the rest in the same order. Each visited source takes the first destination (i+sd) mod N, for i=0..N-1, that it requests, that is not inhibited and that is still free. Because the offsets change, contested grants rotate among the sources over the epochs.
- R9: The LFSR shifts left once at every sampling edge, taking in bit15^bit13^bit12^bit10 as the new bit 0. If `seed_load` is high at an edge, the LFSR is loaded with `seed_val` instead of shifting, and a zero seed is loaded as 1. An edge that is both a sampling edge and a load edge still uses the old LFSR value for its offsets.
- R10: Reset clears all grant outputs to zero and sets the LFSR to `SEED_INIT` (default 16'hACE1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Allocation clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_mat | input | N*N | Request matrix, bit s*N+d = source s wants destination d |
| fe_pri | input | N | Source is a forwarding engine (scanned first) |
| dst_inhibit | input | N | Destination refuses transfers this epoch |
| seed_load | input | 1 | Load `seed_val` into the LFSR at this edge |
| seed_val | input | 16 | LFSR seed value |
| epoch_tick | output | 1 | High in the last cycle of an epoch (sampling edge follows) |
| src_gnt_vld | output | N | Source has a grant this epoch |
| src_gnt_dst | output | N*IW | Granted destination per source |
| dst_sel_vld | output | N | Destination is receiving this epoch |
| dst_sel_src | output | N*IW | Selected source per destination |

## Verification
The assertions check on every cycle that the epoch counter advances regularly and that the LFSR never holds zero. After every publish they also check that outputs are held stable between boundaries, that the destination view matches the source view, and that each published set respects the requests, the inhibits, maximality and forwarding-engine precedence against the sampled inputs. The exact choice among several legal maximal matchings, that is the rotated scan order, the seed loading and the default seed after reset, can only be shown by the bench. The bench predicts each epoch's pairing from the LFSR sequence and compares it with the outputs. It also checks that contested grants move between sources across epochs.

// File: rtl/xalloc_pkg.sv
package xalloc_pkg;
  localparam int LFSR_W = 16;

  // one shift of the scan-order generator: x^16+x^14+x^13+x^11+1
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/xalloc_epoch_timer.sv
module xalloc_epoch_timer #(
  parameter int N = 15,
  parameter int IW = 4,
  parameter int EPOCH_CYC = 8,
  parameter logic [15:0] SEED_INIT = 16'hACE1,
  localparam int PW = (EPOCH_CYC > 1) ? $clog2(EPOCH_CYC) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_load,
  input  logic [15:0]   seed_val,
  output logic          tick,
  output logic [PW-1:0] phase,
  output logic [IW-1:0] src_off,
  output logic [IW-1:0] dst_off
);
  import xalloc_pkg::*;

  logic [PW-1:0]     ph_q;
  logic [LFSR_W-1:0] lfsr_q;

  assign tick  = (ph_q == PW'(EPOCH_CYC - 1));
  assign phase = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      lfsr_q <= SEED_INIT;
    end else begin
      ph_q <= tick ? '0 : ph_q + 1'b1;
      if (seed_load)
        lfsr_q <= (seed_val == '0) ? 16'd1 : seed_val;
      else if (tick)
        lfsr_q <= lfsr_step(lfsr_q);
    end
  end

  assign src_off = IW'(32'(lfsr_q[IW-1:0]) % N);
  assign dst_off = IW'(32'(lfsr_q[2*IW-1:IW]) % N);

  // R1
  phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (ph_q == $past(ph_q) + 1'b1));

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ph_q == '0));

  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R9
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !seed_load) |=> $stable(lfsr_q));
endmodule

// File: rtl/xalloc_scan_slice.sv
module xalloc_scan_slice #(
  parameter int N  = 15,
  parameter int IW = 4,
  parameter int SW = 5
)(
  input  logic [SW-1:0]  step_k,
  input  logic [N*N-1:0] req_q,
  input  logic [N-1:0]   pri_q,
  input  logic [N-1:0]   dfree_in,
  input  logic [IW-1:0]  src_off,
  input  logic [IW-1:0]  dst_off,
  output logic           hit,
  output logic [IW-1:0]  hit_src,
  output logic [IW-1:0]  hit_dst,
  output logic [N-1:0]   dfree_out
);
  function automatic int rot(input int a, input int b);
    int t;
    t = a + b;
    return (t >= N) ? t - N : t;
  endfunction

  int         k, slot, src, dst, cand;
  logic       first_pass, active;
  logic [N-1:0] row;

  always_comb begin
    k          = int'(step_k);
    first_pass = (k < N);
    slot       = first_pass ? k : k - N;
    src        = rot(slot, int'(src_off));
    if (src >= N) src = 0;
    active     = (k < 2 * N) && (pri_q[src] == first_pass);
    row        = req_q[src*N +: N] & dfree_in;
    hit        = 1'b0;
    dst        = 0;
    for (int i = 0; i < N; i++) begin
      cand = rot(i, int'(dst_off));
      if (!hit && active && cand < N && row[cand]) begin
        hit = 1'b1;
        dst = cand;
      end
    end
    dfree_out = dfree_in;
    if (hit) dfree_out[dst] = 1'b0;
    hit_src = IW'(src);
    hit_dst = IW'(dst);
  end
endmodule

// File: rtl/xalloc_grant_bank.sv
module xalloc_grant_bank #(
  parameter int N  = 15,
  parameter int IW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          publish,
  input  logic [N-1:0]  nxt_gv,
  input  logic [N*IW-1:0] nxt_gd,
  output logic [N-1:0]  src_gnt_vld,
  output logic [N*IW-1:0] src_gnt_dst,
  output logic [N-1:0]  dst_sel_vld,
  output logic [N*IW-1:0] dst_sel_src
);
  logic [N-1:0]    nd_vld;
  logic [N*IW-1:0] nd_src;
  int              d;

  always_comb begin
    nd_vld = '0;
    nd_src = '0;
    d      = 0;
    for (int s = 0; s < N; s++) begin
      if (nxt_gv[s]) begin
        d = int'(nxt_gd[s*IW +: IW]);
        if (d < N) begin
          nd_vld[d]          = 1'b1;
          nd_src[d*IW +: IW] = IW'(s);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_gnt_vld <= '0;
      src_gnt_dst <= '0;
      dst_sel_vld <= '0;
      dst_sel_src <= '0;
    end else if (publish) begin
      src_gnt_vld <= nxt_gv;
      src_gnt_dst <= nxt_gd;
      dst_sel_vld <= nd_vld;
      dst_sel_src <= nd_src;
    end
  end

  function automatic logic views_agree(input logic [N-1:0] gv, input logic [N*IW-1:0] gd,
                                       input logic [N-1:0] dv, input logic [N*IW-1:0] ds);
    int t;
    views_agree = 1'b1;
    for (int s = 0; s < N; s++) begin
      if (gv[s]) begin
        t = int'(gd[s*IW +: IW]);
        if (t >= N) views_agree = 1'b0;
        else if (!dv[t] || ds[t*IW +: IW] != IW'(s)) views_agree = 1'b0;
      end
    end
  endfunction

  // R2
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !publish |=> ($stable(src_gnt_vld) && $stable(src_gnt_dst) &&
                  $stable(dst_sel_vld) && $stable(dst_sel_src)));

  // R3
  one_per_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_gnt_vld) == $countones(dst_sel_vld));

  // R3
  view_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    views_agree(src_gnt_vld, src_gnt_dst, dst_sel_vld, dst_sel_src));
endmodule

// File: rtl/epoch_xfer_alloc.sv
module epoch_xfer_alloc #(
  parameter int N = 15,
  parameter int EPOCH_CYC = 8,
  parameter logic [15:0] SEED_INIT = 16'hACE1,
  localparam int IW = (N > 1) ? $clog2(N) : 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*N-1:0]  req_mat,
  input  logic [N-1:0]    fe_pri,
  input  logic [N-1:0]    dst_inhibit,
  input  logic            seed_load,
  input  logic [15:0]     seed_val,
  output logic            epoch_tick,
  output logic [N-1:0]    src_gnt_vld,
  output logic [N*IW-1:0] src_gnt_dst,
  output logic [N-1:0]    dst_sel_vld,
  output logic [N*IW-1:0] dst_sel_src
);
  localparam int RPC = (2 * N + EPOCH_CYC - 1) / EPOCH_CYC;
  localparam int PW  = (EPOCH_CYC > 1) ? $clog2(EPOCH_CYC) : 1;
  localparam int SW  = $clog2(EPOCH_CYC * RPC + 1);

  logic          tick;
  logic [PW-1:0] phase;
  logic [IW-1:0] so_now, sd_now;

  xalloc_epoch_timer #(.N(N), .IW(IW), .EPOCH_CYC(EPOCH_CYC), .SEED_INIT(SEED_INIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
    .tick(tick), .phase(phase), .src_off(so_now), .dst_off(sd_now)
  );

  // epoch snapshot
  logic [N*N-1:0]  req_q;
  logic [N-1:0]    pri_q, inh_q;
  logic [IW-1:0]   so_q, sd_q;
  // running allocation state
  logic [N-1:0]    w_dfree, w_gv;
  logic [N*IW-1:0] w_gd;

  logic [N-1:0]  fchain [RPC+1];
  logic [RPC-1:0] s_hit;
  logic [IW-1:0] s_src [RPC];
  logic [IW-1:0] s_dst [RPC];
  logic [SW-1:0] step_k [RPC];

  assign fchain[0] = w_dfree;

  for (genvar r = 0; r < RPC; r++) begin : g_slice
    assign step_k[r] = SW'(phase) * SW'(RPC) + SW'(r);
    xalloc_scan_slice #(.N(N), .IW(IW), .SW(SW)) u_slice (
      .step_k(step_k[r]), .req_q(req_q), .pri_q(pri_q), .dfree_in(fchain[r]),
      .src_off(so_q), .dst_off(sd_q), .hit(s_hit[r]), .hit_src(s_src[r]),
      .hit_dst(s_dst[r]), .dfree_out(fchain[r+1])
    );
  end

  logic [N-1:0]    c_gv;
  logic [N*IW-1:0] c_gd;

  always_comb begin
    c_gv = w_gv;
    c_gd = w_gd;
    for (int r = 0; r < RPC; r++) begin
      if (s_hit[r]) begin
        c_gv[s_src[r]]             = 1'b1;
        c_gd[int'(s_src[r])*IW +: IW] = s_dst[r];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      pri_q   <= '0;
      inh_q   <= '0;
      so_q    <= '0;
      sd_q    <= '0;
      w_dfree <= '0;
      w_gv    <= '0;
      w_gd    <= '0;
    end else if (tick) begin
      req_q   <= req_mat;
      pri_q   <= fe_pri;
      inh_q   <= dst_inhibit;
      so_q    <= so_now;
      sd_q    <= sd_now;
      w_dfree <= ~dst_inhibit;
      w_gv    <= '0;
      w_gd    <= '0;
    end else begin
      w_dfree <= fchain[RPC];
      w_gv    <= c_gv;
      w_gd    <= c_gd;
    end
  end

  xalloc_grant_bank #(.N(N), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n), .publish(tick), .nxt_gv(c_gv), .nxt_gd(c_gd),
    .src_gnt_vld(src_gnt_vld), .src_gnt_dst(src_gnt_dst),
    .dst_sel_vld(dst_sel_vld), .dst_sel_src(dst_sel_src)
  );

  assign epoch_tick = tick;

  function automatic logic unrequested(input logic [N-1:0] gv, input logic [N*IW-1:0] gd,
                                       input logic [N*N-1:0] rq);
    int t;
    unrequested = 1'b0;
    for (int s = 0; s < N; s++) begin
      t = int'(gd[s*IW +: IW]);
      if (gv[s] && (t >= N || !rq[s*N + t])) unrequested = 1'b1;
    end
  endfunction

  function automatic logic left_open(input logic [N-1:0] gv, input logic [N-1:0] dv,
                                     input logic [N*N-1:0] rq, input logic [N-1:0] inh);
    left_open = 1'b0;
    for (int s = 0; s < N; s++)
      for (int t = 0; t < N; t++)
        if (!gv[s] && !dv[t] && !inh[t] && rq[s*N + t]) left_open = 1'b1;
  endfunction

  function automatic logic fe_passed_over(input logic [N-1:0] gv, input logic [N*N-1:0] rq,
                                          input logic [N-1:0] pr, input logic [N-1:0] inh,
                                          input logic [N-1:0] dv, input logic [N*IW-1:0] ds);
    int o;
    fe_passed_over = 1'b0;
    for (int s = 0; s < N; s++)
      for (int t = 0; t < N; t++) begin
        o = int'(ds[t*IW +: IW]);
        if (pr[s] && !gv[s] && rq[s*N + t] && !inh[t] && dv[t] && o < N && !pr[o])
          fe_passed_over = 1'b1;
      end
  endfunction

  // R4
  gnt_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !unrequested(src_gnt_vld, src_gnt_dst, $past(req_q)));

  // R5
  inhibit_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((dst_sel_vld & $past(inh_q)) == '0));

  // R6
  maximal_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !left_open(src_gnt_vld, dst_sel_vld, $past(req_q), $past(inh_q)));

  // R7
  fe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !fe_passed_over(src_gnt_vld, $past(req_q), $past(pri_q), $past(inh_q),
                             dst_sel_vld, dst_sel_src));
endmodule

// File: tb/test_epoch_xfer_alloc.sv
module test_epoch_xfer_alloc;
  localparam int N  = 15;
  localparam int IW = 4;
  localparam int NN = N * N;
  localparam int EP = 8;

  typedef struct packed {
    logic [3:0]  kind;   // 0 all, 1 shift by arg, 2 all to dest arg, 3 dest mask arg, 4 none
    logic [14:0] arg;
    logic [14:0] pri;
    logic [14:0] inh;
    logic [4:0]  cnt;    // expected number of grants
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 15'd0,     15'h0000, 15'h0000, 5'd15},
    '{4'd0, 15'd0,     15'h00FF, 15'h0003, 5'd13},
    '{4'd1, 15'd3,     15'h0000, 15'h0000, 5'd15},
    '{4'd1, 15'd7,     15'h0000, 15'h0101, 5'd13},
    '{4'd2, 15'd5,     15'h4000, 15'h0000, 5'd1},
    '{4'd2, 15'd5,     15'h0000, 15'h0020, 5'd0},
    '{4'd3, 15'h00F0,  15'h0000, 15'h0010, 5'd3},
    '{4'd4, 15'd0,     15'h0000, 15'h0000, 5'd0},
    '{4'd3, 15'h7FFF,  15'h5555, 15'h7000, 5'd12},
    '{4'd1, 15'd0,     15'h0000, 15'h0000, 5'd15},
    '{4'd0, 15'd0,     15'h0000, 15'h7FFF, 5'd0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NN-1:0]   req_mat = '0;
  logic [N-1:0]    fe_pri = '0;
  logic [N-1:0]    dst_inhibit = '0;
  logic            seed_load = 1'b0;
  logic [15:0]     seed_val = '0;
  logic            epoch_tick;
  logic [N-1:0]    src_gnt_vld;
  logic [N*IW-1:0] src_gnt_dst;
  logic [N-1:0]    dst_sel_vld;
  logic [N*IW-1:0] dst_sel_src;

  int tests = 0;
  int fails = 0;

  logic [15:0]     m_lfsr;
  logic [N-1:0]    e_gv;
  logic [N*IW-1:0] e_gd;
  string           prev_tag;

  always #5 clk = ~clk;

  epoch_xfer_alloc i_epoch_xfer_alloc (
    .clk(clk), .rst_n(rst_n), .req_mat(req_mat), .fe_pri(fe_pri),
    .dst_inhibit(dst_inhibit), .seed_load(seed_load), .seed_val(seed_val),
    .epoch_tick(epoch_tick), .src_gnt_vld(src_gnt_vld), .src_gnt_dst(src_gnt_dst),
    .dst_sel_vld(dst_sel_vld), .dst_sel_src(dst_sel_src)
  );

  function automatic logic [15:0] lstep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [NN-1:0] expand(input logic [3:0] kind, input logic [14:0] arg);
    logic [NN-1:0] m;
    m = '0;
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++)
        case (kind)
          4'd0: m[s*N+d] = 1'b1;
          4'd1: m[s*N+d] = (d == (s + int'(arg)) % N);
          4'd2: m[s*N+d] = (d == int'(arg));
          4'd3: m[s*N+d] = arg[d];
          default: m[s*N+d] = 1'b0;
        endcase
    return m;
  endfunction

  // reference pairing computed from R8
  task automatic model(input logic [NN-1:0] rq, input logic [N-1:0] pr, input logic [N-1:0] inh,
                       input logic [15:0] lf, output logic [N-1:0] gv, output logic [N*IW-1:0] gd);
    int so, sd, s, d;
    logic [N-1:0] fr;
    so = int'(lf[3:0]) % N;
    sd = int'(lf[7:4]) % N;
    fr = ~inh;
    gv = '0;
    gd = '0;
    for (int pass = 0; pass < 2; pass++)
      for (int j = 0; j < N; j++) begin
        s = (j + so) % N;
        if (pr[s] == (pass == 0)) begin
          for (int i = 0; i < N; i++) begin
            d = (i + sd) % N;
            if (!gv[s] && rq[s*N+d] && fr[d]) begin
              gv[s] = 1'b1;
              gd[s*IW +: IW] = IW'(d);
              fr[d] = 1'b0;
            end
          end
        end
      end
  endtask

  task automatic check_out(input string tag, input logic [N-1:0] gv, input logic [N*IW-1:0] gd);
    logic [N-1:0]    dv;
    logic [N*IW-1:0] ds;
    int              d;
    dv = '0;
    ds = '0;
    for (int s = 0; s < N; s++)
      if (gv[s]) begin
        d = int'(gd[s*IW +: IW]);
        dv[d] = 1'b1;
        ds[d*IW +: IW] = IW'(s);
      end
    tests++;
    if (src_gnt_vld !== gv || src_gnt_dst !== gd || dst_sel_vld !== dv || dst_sel_src !== ds) begin
      fails++;
      $display("FAIL %s: got gv=%h gd=%h dv=%h ds=%h, expected gv=%h gd=%h dv=%h ds=%h",
               tag, src_gnt_vld, src_gnt_dst, dst_sel_vld, dst_sel_src, gv, gd, dv, ds);
    end
  endtask

  task automatic expect_val(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_tick();
    while (!epoch_tick) @(negedge clk);
  endtask

  // drive one epoch of inputs; checks the previous epoch's grants at publish and at end of hold
  task automatic step(input logic [NN-1:0] rq, input logic [N-1:0] pr, input logic [N-1:0] inh,
                      input logic ld, input logic [15:0] sv, input string tag);
    logic [N-1:0]    ngv;
    logic [N*IW-1:0] ngd;
    wait_tick();
    req_mat = rq;
    fe_pri = pr;
    dst_inhibit = inh;
    seed_load = ld;
    seed_val = sv;
    model(rq, pr, inh, m_lfsr, ngv, ngd);
    m_lfsr = ld ? ((sv == 16'd0) ? 16'd1 : sv) : lstep(m_lfsr);
    @(posedge clk);
    @(negedge clk);
    seed_load = 1'b0;
    check_out({prev_tag, " publish"}, e_gv, e_gd);
    repeat (EP - 1) @(negedge clk);
    check_out({prev_tag, " R2 hold"}, e_gv, e_gd);
    e_gv = ngv;
    e_gd = ngd;
    prev_tag = tag;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_mat = '0;
    fe_pri = '0;
    dst_inhibit = '0;
    seed_load = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R10 in reset", '0, '0);
    expect_val("R1 no tick in reset", int'(epoch_tick), 0);
    rst_n = 1'b1;
    m_lfsr = 16'hACE1;
    e_gv = '0;
    e_gd = '0;
    prev_tag = "R10 after reset";
  endtask

  initial begin
    #(10 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] seen;
    int gap;
    do_reset();

    // R1: first tick position and period
    gap = 0;
    while (!epoch_tick) begin
      @(negedge clk);
      gap++;
    end
    expect_val("R1 first tick", gap, EP - 1);
    @(negedge clk);
    gap = 1;
    while (!epoch_tick) begin
      @(negedge clk);
      gap++;
    end
    expect_val("R1 tick period", gap, EP);
    check_out("R10 zero before traffic", '0, '0);

    // seed load together with an idle epoch (R9)
    step('0, '0, '0, 1'b1, 16'h1234, "R9 seed idle");

    // table walk (R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < NV; i++) begin
      step(expand(VECS[i].kind, VECS[i].arg), VECS[i].pri, VECS[i].inh, 1'b0, 16'd0,
           $sformatf("R8 vec%0d", i));
      if (i > 0)
        expect_val($sformatf("R3 R6 grant count vec%0d", i - 1),
                   $countones(src_gnt_vld), int'(VECS[i-1].cnt));
    end
    step('0, '0, '0, 1'b0, 16'd0, "R8 flush");
    expect_val("R5 all inhibited count", $countones(src_gnt_vld), int'(VECS[NV-1].cnt));

    // R7: one forwarding engine contends with all others for one destination
    for (int e = 0; e < 4; e++) begin
      step(expand(4'd2, 15'd9), 15'h0004, '0, 1'b0, 16'd0, "R7 fe wins");
      if (e > 0) expect_val("R7 fe source 2 granted", int'(src_gnt_vld), 32'h4);
    end

    // R8: contested destination rotates among sources
    seen = '0;
    for (int e = 0; e < 7; e++) begin
      step(expand(4'd2, 15'd3), '0, '0, 1'b0, 16'd0, "R8 rotate");
      if (e > 0) seen |= src_gnt_vld;
    end
    tests++;
    if ($countones(seen) < 2) begin
      fails++;
      $display("FAIL R8 rotation: got %0d distinct winners, expected at least 2", $countones(seen));
    end

    // R9: zero seed acts as 1, then repeat of a known seed
    step(expand(4'd0, 15'd0), '0, '0, 1'b1, 16'd0, "R9 zero seed load");
    step(expand(4'd3, 15'h0F0F), 15'h0300, '0, 1'b0, 16'd0, "R9 after zero seed");
    step(expand(4'd0, 15'd0), '0, 15'h0008, 1'b1, 16'hBEEF, "R9 seed BEEF");
    step(expand(4'd0, 15'd0), '0, 15'h0008, 1'b0, 16'd0, "R9 seeded run");
    step('0, '0, '0, 1'b0, 16'd0, "R9 flush");

    // R10: default seed after a second reset
    do_reset();
    step(expand(4'd2, 15'd11), '0, '0, 1'b0, 16'd0, "R10 default seed");
    step(expand(4'd0, 15'd0), '0, '0, 1'b0, 16'd0, "R10 default seed full");
    step('0, '0, '0, 1'b0, 16'd0, "R10 flush");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule